// File: doc/BRIEF.md
# I2C Event Interrupt and DMA Router

This block sits beside an I2C controller. It gathers the controller's one-cycle event pulses into sticky status flags and drives two outputs from them: one CPU interrupt line and one DMA request line. The six event sources are:

- byte transfer complete
- own-address match
- arbitration lost
- SCL-low timeout
- SCL-high/SDA-low timeout
- wakeup address match

Software sees the block through a small two-register interface. The control register holds four enables. The status register holds one shared interrupt flag and one flag per source, and every status bit is cleared by writing 1 to it.

In interrupt mode, the shared flag drives the CPU interrupt. In DMA mode, byte-complete events become a DMA request. That request stays asserted until the DMA engine signals a data-register access, and only the two error sources, arbitration loss and SCL-low timeout, still interrupt the CPU.

The bus protocol engine, the timeout counters and the DMA controller live elsewhere.

Top module: `i2cev_router`

## Requirements
- R1: After a synchronous reset, every status flag, every control bit, `irq` and `dma_req` are 0.
- R2: `evt_pulse` bit k (0 byte done, 1 address match, 2 arbitration lost, 3 SCL-low timeout, 4 SCL-high/SDA-low timeout, 5 wakeup match) sets status bit k+1 on the next clock edge, whatever the enables are.
- R3: Status bit 0, the shared interrupt flag, is set by any of event bits 0 to 3 unconditionally. Event bit 4 sets it only while control bit 2 (stuck-bus enable) is 1. Event bit 5 sets it only while control bit 3 (wake enable) is 1.
- R4: With control bit 1 (DMA mode) at 0, `irq` equals control bit 0 (global interrupt enable) AND status bit 0.
- R5: A write with `reg_sel`=1 clears each status bit whose `reg_wdata` bit is 1 and leaves the bits written 0 unchanged.
- R6: When an event sets a status bit in the same cycle as a write of 1 to that bit, the bit ends set.
- R7: With control bits 0 and 1 both set, a byte-done event asserts `dma_req`. The request stays at 1 until a cycle with `data_strobe` high.
- R8: With control bits 0 and 1 both set, `irq` equals status bit 3 (arbitration lost) OR status bit 4 (SCL-low timeout). Byte-done, address, stuck-bus and wake flags do not raise it.
- R9: A byte-done event does not set `dma_req` unless control bits 0 and 1 are both 1. A byte-done event in a cycle with `data_strobe` high leaves `dma_req` at 1.
- R10: A write with `reg_sel`=0 loads control bits [3:0] from `reg_wdata[3:0]`. With `reg_sel`=0, `reg_rdata` returns them with zeros above. With `reg_sel`=1, it returns the seven status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 6 | One-cycle event pulses from the controller, bit order as in R2 |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 7 | Write data (control value or clear mask) |
| reg_rdata | output | 7 | Read data of the selected register |
| data_strobe | input | 1 | Data-register access by the DMA engine; acknowledges the request |
| irq | output | 1 | CPU interrupt request |
| dma_req | output | 1 | DMA request level |

## Verification
The block has only package constants, so the bench builds it with six sources and seven-bit registers. At that size it can drive every event combination and every enable setting. A behavioural model runs alongside, and its flags, interrupt, request and read data are compared every cycle. Directed phases cover each source alone, partial clears, a set that collides with a clear, DMA hold and acknowledge, and a strobe that collides with a new event. A long random phase then mixes events, writes, strobes and mode changes.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
    localparam int EV_N  = 6;
    localparam int REG_W = EV_N + 1;
    localparam int CTL_W = 4;

    localparam int EV_DONE  = 0;
    localparam int EV_ADDR  = 1;
    localparam int EV_ARB   = 2;
    localparam int EV_SCLTO = 3;
    localparam int EV_STUCK = 4;
    localparam int EV_WAKE  = 5;

    localparam int SB_SHARED = 0;

    typedef struct packed {
        logic wake_en;
        logic stuck_en;
        logic dma_mode;
        logic irq_en;
    } ctrl_t;

    function automatic int stat_bit(input int ev);
        return ev + 1;
    endfunction

    function automatic logic shared_hit(input logic [EV_N-1:0] ev, input ctrl_t c);
        return ev[EV_DONE] | ev[EV_ADDR] | ev[EV_ARB] | ev[EV_SCLTO]
             | (ev[EV_STUCK] & c.stuck_en) | (ev[EV_WAKE] & c.wake_en);
    endfunction
endpackage

// File: rtl/i2cev_ctrl.sv
module i2cev_ctrl
    import i2cev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctrl_t            ctrl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr)
            ctrl <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/i2cev_flags.sv
module i2cev_flags
    import i2cev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [EV_N-1:0]  ev,
    input  logic [REG_W-1:0] clr,
    output logic [REG_W-1:0] flags
);
    logic [REG_W-1:0] set_v;

    always_comb begin
        set_v            = '0;
        set_v[SB_SHARED] = shared_hit(ev, ctrl);
        for (int k = 0; k < EV_N; k++)
            set_v[stat_bit(k)] = ev[k];
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[b] <= 1'b0;
            else
                flags[b] <= set_v[b] | (flags[b] & ~clr[b]);
        end

        assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
            (clr[b] && !set_v[b]) |=> !flags[b]);

        // R6: a set in the clearing cycle survives
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
            (set_v[b] && clr[b]) |=> flags[b]);
    end

    for (genvar k = 0; k < EV_N; k++) begin : g_ev
        assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
            ev[k] |=> flags[k+1]);
    end
endmodule

// File: rtl/i2cev_route.sv
module i2cev_route
    import i2cev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [REG_W-1:0] flags,
    input  logic             done_ev,
    input  logic             strobe,
    output logic             irq,
    output logic             dma_req
);
    logic err_any;
    logic dma_set;

    assign err_any = flags[stat_bit(EV_ARB)] | flags[stat_bit(EV_SCLTO)];
    assign dma_set = done_ev & ctrl.irq_en & ctrl.dma_mode;

    always_comb begin
        if (!ctrl.irq_en)
            irq = 1'b0;
        else if (ctrl.dma_mode)
            irq = err_any;
        else
            irq = flags[SB_SHARED];
    end

    always_ff @(posedge clk) begin
        if (rst)
            dma_req <= 1'b0;
        else
            dma_req <= dma_set | (dma_req & ~strobe);
    end

    assert_dma_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !strobe) |=> dma_req);

    assert_dma_gate_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(ctrl.irq_en && ctrl.dma_mode && done_ev));
endmodule

// File: rtl/i2cev_router.sv
module i2cev_router
    import i2cev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EV_N-1:0]  evt_pulse,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             data_strobe,
    output logic             irq,
    output logic             dma_req
);
    ctrl_t            ctrl;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] clr_mask;
    logic             ctl_wr;

    assign ctl_wr   = reg_we & ~reg_sel;
    assign clr_mask = (reg_we & reg_sel) ? reg_wdata : '0;

    i2cev_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (reg_wdata[CTL_W-1:0]),
        .ctrl  (ctrl)
    );

    i2cev_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .ev    (evt_pulse),
        .clr   (clr_mask),
        .flags (flags)
    );

    i2cev_route u_route (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .flags   (flags),
        .done_ev (evt_pulse[EV_DONE]),
        .strobe  (data_strobe),
        .irq     (irq),
        .dma_req (dma_req)
    );

    always_comb begin
        if (reg_sel)
            reg_rdata = flags;
        else
            reg_rdata = {{(REG_W-CTL_W){1'b0}}, ctrl};
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq && !dma_req && flags == '0));
endmodule

// File: tb/i2cev_router_test.sv
module i2cev_router_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] evt_pulse = '0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [6:0] reg_wdata = '0;
    logic [6:0] reg_rdata;
    logic       data_strobe = 1'b0;
    logic       irq;
    logic       dma_req;

    int errors = 0;
    int checks = 0;

    bit [3:0] m_ctrl;
    bit [6:0] m_st;
    bit       m_dma;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cev_router uut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_strobe(data_strobe), .irq(irq), .dma_req(dma_req)
    );

    // behavioural reference, updated at each edge from the stable inputs
    always @(posedge clk) begin
        bit [6:0] clr;
        bit [6:0] setv;
        if (rst) begin
            m_ctrl = 0; m_st = 0; m_dma = 0;
        end else begin
            clr = (reg_we && reg_sel) ? reg_wdata : 7'd0;
            setv = {evt_pulse, 1'b0};
            if (evt_pulse[3:0] != 0 || (evt_pulse[4] && m_ctrl[2]) || (evt_pulse[5] && m_ctrl[3]))
                setv[0] = 1'b1;
            m_dma = (evt_pulse[0] && m_ctrl[0] && m_ctrl[1]) || (m_dma && !data_strobe);
            m_st = (m_st & ~clr) | setv;
            if (reg_we && !reg_sel) m_ctrl = reg_wdata[3:0];
        end
    end

    function automatic bit exp_irq();
        if (!m_ctrl[0]) return 1'b0;
        if (m_ctrl[1]) return m_st[3] | m_st[4];
        return m_st[0];
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "irq", irq, exp_irq());
        check(tag, "dma_req", dma_req, m_dma);
        check(tag, "rdata", reg_rdata, reg_sel ? m_st : {3'b0, m_ctrl});
    endtask

    // one cycle: drive at negedge, step one edge, compare at next negedge
    task automatic cyc(input string tag, input bit [5:0] ev, input bit we,
                       input bit sel, input bit [6:0] wd, input bit strb);
        evt_pulse = ev; reg_we = we; reg_sel = sel; reg_wdata = wd; data_strobe = strb;
        @(posedge clk);
        @(negedge clk);
        evt_pulse = '0; reg_we = 1'b0; data_strobe = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag, input bit sel);
        cyc(tag, 6'd0, 1'b0, sel, 7'd0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state on both registers
        idle("R1", 1'b1);
        check("R1", "status", reg_rdata, 0);
        idle("R1", 1'b0);
        check("R1", "ctrl", reg_rdata, 0);

        // R10: control write and readback
        cyc("R10", 6'd0, 1'b1, 1'b0, 7'h7F, 1'b0);
        check("R10", "ctrl", reg_rdata, 7'h0F);
        cyc("R10", 6'd0, 1'b1, 1'b0, 7'h01, 1'b0);
        check("R10", "ctrl", reg_rdata, 7'h01);

        // R2, R3, R4: each source alone with stuck/wake enables off
        for (int k = 0; k < 6; k++) begin
            cyc("R2", 6'd1 << k, 1'b0, 1'b1, 7'd0, 1'b0);
            check("R2", "status", reg_rdata, (7'd1 << (k+1)) | ((k < 4) ? 7'd1 : 7'd0));
            check("R4", "irq", irq, (k < 4) ? 1 : 0);
            cyc("R5", 6'd0, 1'b1, 1'b1, 7'h7F, 1'b0);
            check("R5", "status cleared", reg_rdata, 0);
        end
        // R3: stuck and wake reach the shared flag once enabled
        cyc("R3", 6'd0, 1'b1, 1'b0, 7'h0D, 1'b0);
        cyc("R3", 6'h10, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R3", "status", reg_rdata, 7'h21);
        check("R3", "irq", irq, 1);
        cyc("R3", 6'd0, 1'b1, 1'b1, 7'h7F, 1'b0);
        cyc("R3", 6'h20, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R3", "status", reg_rdata, 7'h41);
        // R4: interrupt gated by global enable
        cyc("R4", 6'd0, 1'b1, 1'b0, 7'h0C, 1'b0);
        check("R4", "irq off", irq, 0);
        cyc("R4", 6'd0, 1'b1, 1'b0, 7'h0D, 1'b0);
        check("R4", "irq on", irq, 1);

        // R5: partial clear keeps the unselected bits
        cyc("R5", 6'h03, 1'b0, 1'b1, 7'd0, 1'b0);
        cyc("R5", 6'd0, 1'b1, 1'b1, 7'h02, 1'b0);
        check("R5", "partial", reg_rdata, 7'h45);
        // R6: event and clear in one cycle
        cyc("R6", 6'h01, 1'b1, 1'b1, 7'h7F, 1'b0);
        check("R6", "set wins", reg_rdata, 7'h03);
        cyc("R6", 6'd0, 1'b1, 1'b1, 7'h7F, 1'b0);

        // R7, R8: DMA mode
        cyc("R7", 6'd0, 1'b1, 1'b0, 7'h03, 1'b0);
        cyc("R7", 6'h01, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R7", "dma set", dma_req, 1);
        check("R8", "no irq on done", irq, 0);
        cyc("R8", 6'h02, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R8", "no irq on addr", irq, 0);
        repeat (4) idle("R7", 1'b1);
        check("R7", "dma held", dma_req, 1);
        cyc("R7", 6'd0, 1'b0, 1'b1, 7'd0, 1'b1);
        check("R7", "dma acked", dma_req, 0);
        cyc("R8", 6'h04, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R8", "irq on arb", irq, 1);
        cyc("R8", 6'd0, 1'b1, 1'b1, 7'h08, 1'b0);
        check("R8", "arb cleared", irq, 0);
        cyc("R8", 6'h08, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R8", "irq on scl timeout", irq, 1);
        cyc("R8", 6'd0, 1'b1, 1'b1, 7'h7F, 1'b0);

        // R9: strobe colliding with a new byte-done keeps the request
        cyc("R9", 6'h01, 1'b0, 1'b1, 7'd0, 1'b0);
        cyc("R9", 6'h01, 1'b0, 1'b1, 7'd0, 1'b1);
        check("R9", "strobe+event", dma_req, 1);
        cyc("R9", 6'd0, 1'b0, 1'b1, 7'd0, 1'b1);
        // R9: no request without both enables
        cyc("R9", 6'd0, 1'b1, 1'b0, 7'h02, 1'b0);
        cyc("R9", 6'h01, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R9", "no irq_en", dma_req, 0);
        cyc("R9", 6'd0, 1'b1, 1'b0, 7'h01, 1'b0);
        cyc("R9", 6'h01, 1'b0, 1'b1, 7'd0, 1'b0);
        check("R9", "no dma_mode", dma_req, 0);

        // random mix, compared with the model every cycle
        for (int n = 0; n < 2000; n++) begin
            bit [5:0] ev;
            bit we;
            bit sel;
            ev  = 6'($urandom) & 6'($urandom);
            we  = ($urandom % 4) == 0;
            sel = 1'($urandom);
            cyc("R3/R4/R5/R6/R7/R8/R9", ev, we, sel, 7'($urandom), ($urandom % 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule